// File: doc/BRIEF.md
# Per-Pin Pass/Fail Result Accumulator

This block is the digital judging path behind a bank of tester pin channels. Every channel always carries two comparator bits: one saying the sampled level sits above the high threshold, the other saying it sits below the low threshold. A small register interface sets three things:
- the role of each channel, which is either stimulus input or monitored output;
- a per-channel observe mask;
- a mode bit that enables automatic accumulation.

On each test step the block judges every channel against that step's expected level. It reports three views of the result:
- the failing-pin vector;
- one OR-reduced step verdict;
- a sticky cumulative flag, which is fed automatically at every pattern-sentence boundary when accumulation is on.

The cumulative flag only shows that a failure happened somewhere in the run. It does not say which pin or which step failed. A host sets up the roles and masks, then pulses the step strobe once per pattern vector and the sentence strobe at sentence ends. For long patterns it reads only the cumulative flag, and it clears that flag with an explicit command.

Top module: `pin_result_accum`

## Requirements
- R1: After a synchronous active-low reset, every channel is a stimulus input, no channel is observed, automatic accumulation is off, and `pin_fail`, `step_fail`, `step_valid` and `cum_fail` are all 0.
- R2: A write with `cfg_we`=1 stores `cfg_wdata` into a register chosen by `cfg_addr`: 0 selects roles (bit i = 1 makes channel i a monitored output), 1 selects the observe mask (bit i = 1 observes channel i), and 2 selects the mode, where bit 0 enables automatic accumulation. Address 3 is ignored. The new value governs steps strobed in later cycles, not a step strobed in the same cycle.
- R3: When `step_strobe` is 1, channel i is judged failing in the following cycle's `pin_fail[i]` if it is an observed monitored output and either `step_expect[i]`=1 with `cmp_above_hi[i]`=0, or `step_expect[i]`=0 with `cmp_below_lo[i]`=0. `pin_fail` holds its value until the next strobe.
- R4: A channel that is unobserved or set as a stimulus input never shows in `pin_fail`, whatever its comparator bits are.
- R5: `step_fail` is the OR of the `pin_fail` vector captured by the same strobe. `step_valid` is 1 for exactly the one cycle after each strobe.
- R6: With accumulation on, a `sentence_end` pulse ORs the present step verdict into `cum_fail`. If `step_strobe` is high in the same cycle, the verdict of that step is the one used.
- R7: With accumulation off, `sentence_end` leaves `cum_fail` unchanged.
- R8: `cum_fail` stays set until `cum_clear` is pulsed. A clear in the same cycle as an accumulating sentence end wins, so `cum_fail` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select: 0 role, 1 observe, 2 mode |
| cfg_wdata | input | NPINS | Register write data |
| step_strobe | input | 1 | Judge the current step |
| step_expect | input | NPINS | Expected level per channel for this step |
| cmp_above_hi | input | NPINS | Level is above the high threshold |
| cmp_below_lo | input | NPINS | Level is below the low threshold |
| sentence_end | input | 1 | End of a pattern sentence |
| cum_clear | input | 1 | Clear the cumulative flag |
| pin_fail | output | NPINS | Per-channel result of the last judged step |
| step_fail | output | 1 | OR of per-channel results of the last step |
| step_valid | output | 1 | One-cycle pulse after a judged step |
| cum_fail | output | 1 | Sticky cumulative failure flag |

## Verification
The two functions that collide are judging a step and closing a sentence. When `step_strobe` and `sentence_end` arrive in the same cycle, the cumulative flag must take in the verdict of the step being strobed, not the stale one. The bench forces this collision directly, with a failing step after a passing one, and it also lets it occur at random during long runs. Its reference model captures the verdict and accumulates it in the same cycle before comparing `cum_fail`. The bench also drives a clear together with an accumulating sentence end and expects the flag to read 0.

// File: rtl/pra_pkg.sv
// Shared definitions for the pin result accumulator.
package pra_pkg;
    typedef enum logic [1:0] {
        SEL_ROLE    = 2'd0,
        SEL_OBSERVE = 2'd1,
        SEL_MODE    = 2'd2,
        SEL_NONE    = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pra_cfg_regs.sv
// Configuration registers: channel roles, observe mask, accumulation mode.
// Assumes one write per cycle; writes to the unused select are dropped.
module pra_cfg_regs #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [1:0]       addr,
    input  logic [NPINS-1:0] wdata,
    output logic [NPINS-1:0] role_out,
    output logic [NPINS-1:0] observe,
    output logic             auto_en
);
    import pra_pkg::*;

    reg_sel_e sel;
    assign sel = reg_sel_e'(addr);

    // Register update on a write, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            role_out <= '0;
            observe  <= '0;
            auto_en  <= 1'b0;
        end else if (we) begin
            case (sel)
                SEL_ROLE:    role_out <= wdata;
                SEL_OBSERVE: observe  <= wdata;
                SEL_MODE:    auto_en  <= wdata[0];
                default:     ;
            endcase
        end
    end
endmodule

// File: rtl/pra_pin_judge.sv
// Per-channel judging: masks by role and observe, compares against the
// expected level, captures the vector and its OR on each step strobe.
// Assumes comparator bits are already synchronous to clk.
module pra_pin_judge #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [NPINS-1:0] role_out,
    input  logic [NPINS-1:0] observe,
    input  logic [NPINS-1:0] expect_lvl,
    input  logic [NPINS-1:0] above_hi,
    input  logic [NPINS-1:0] below_lo,
    output logic             present_now,
    output logic [NPINS-1:0] fail_q,
    output logic             present_q,
    output logic             valid_q
);
    logic [NPINS-1:0] fail_now;

    // One judging cell per channel.
    for (genvar i = 0; i < NPINS; i++) begin : g_cell
        logic active;
        logic miss;
        assign active      = role_out[i] & observe[i];
        assign miss        = expect_lvl[i] ? ~above_hi[i] : ~below_lo[i];
        assign fail_now[i] = active & miss;
    end

    assign present_now = |fail_now;

    // Capture the per-channel and step verdicts on the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_q    <= '0;
            present_q <= 1'b0;
        end else if (strobe) begin
            fail_q    <= fail_now;
            present_q <= present_now;
        end
    end

    // Step-valid pulse for one cycle after each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) valid_q <= 1'b0;
        else        valid_q <= strobe;
    end
endmodule

// File: rtl/pra_cum_store.sv
// Sticky cumulative failure flag fed at sentence ends in automatic mode.
// A strobe in the same cycle contributes its fresh verdict; clear wins.
module pra_cum_store (
    input  logic clk,
    input  logic rst_n,
    input  logic auto_en,
    input  logic sent_end,
    input  logic clear,
    input  logic strobe,
    input  logic present_now,
    input  logic present_q,
    output logic cum
);
    logic verdict;
    assign verdict = strobe ? present_now : present_q;

    // Accumulate or clear the cumulative flag.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cum <= 1'b0;
        else if (clear)                cum <= 1'b0;
        else if (sent_end && auto_en)  cum <= cum | verdict;
    end
endmodule

// File: rtl/pin_result_accum.sv
// Top of the pin result accumulator: configuration, per-channel judging
// and cumulative storage. Assumes all inputs are synchronous to clk.
module pin_result_accum #(
    parameter int NPINS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [NPINS-1:0] cfg_wdata,
    input  logic             step_strobe,
    input  logic [NPINS-1:0] step_expect,
    input  logic [NPINS-1:0] cmp_above_hi,
    input  logic [NPINS-1:0] cmp_below_lo,
    input  logic             sentence_end,
    input  logic             cum_clear,
    output logic [NPINS-1:0] pin_fail,
    output logic             step_fail,
    output logic             step_valid,
    output logic             cum_fail
);
    logic [NPINS-1:0] role_q;
    logic [NPINS-1:0] observe_q;
    logic             auto_en;
    logic             present_now;

    pra_cfg_regs #(.NPINS(NPINS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .role_out(role_q), .observe(observe_q),
        .auto_en(auto_en)
    );

    pra_pin_judge #(.NPINS(NPINS)) u_judge (
        .clk(clk), .rst_n(rst_n), .strobe(step_strobe),
        .role_out(role_q), .observe(observe_q), .expect_lvl(step_expect),
        .above_hi(cmp_above_hi), .below_lo(cmp_below_lo),
        .present_now(present_now), .fail_q(pin_fail),
        .present_q(step_fail), .valid_q(step_valid)
    );

    pra_cum_store u_cum (
        .clk(clk), .rst_n(rst_n), .auto_en(auto_en),
        .sent_end(sentence_end), .clear(cum_clear), .strobe(step_strobe),
        .present_now(present_now), .present_q(step_fail), .cum(cum_fail)
    );
endmodule

// File: rtl/pra_checker.sv
// Temporal checks on the accumulator, bound to the top module.
module pra_checker #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             step_strobe,
    input logic             sentence_end,
    input logic             cum_clear,
    input logic [NPINS-1:0] role_q,
    input logic [NPINS-1:0] observe_q,
    input logic             auto_en,
    input logic [NPINS-1:0] pin_fail,
    input logic             step_fail,
    input logic             step_valid,
    input logic             cum_fail
);
    p_pin_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !step_strobe |=> $stable(pin_fail));

    p_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_strobe && (role_q & observe_q) == '0) |=> pin_fail == '0);

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_strobe |=> step_valid);

    p_step_or_r5: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_fail == (|pin_fail)));

    p_cum_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cum_fail) |-> ($past(sentence_end) && $past(auto_en)));

    p_cum_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cum_fail && !cum_clear) |=> cum_fail);

    p_cum_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cum_clear |=> !cum_fail);
endmodule

bind pin_result_accum pra_checker #(.NPINS(NPINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .step_strobe(step_strobe),
    .sentence_end(sentence_end), .cum_clear(cum_clear),
    .role_q(role_q), .observe_q(observe_q), .auto_en(auto_en),
    .pin_fail(pin_fail), .step_fail(step_fail), .step_valid(step_valid),
    .cum_fail(cum_fail)
);

// File: tb/tb_pin_result_accum.sv
module tb_pin_result_accum;
    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [1:0]    cfg_addr;
    logic [NP-1:0] cfg_wdata;
    logic          step_strobe;
    logic [NP-1:0] step_expect, cmp_above_hi, cmp_below_lo;
    logic          sentence_end, cum_clear;
    logic [NP-1:0] pin_fail;
    logic          step_fail, step_valid, cum_fail;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference state
    logic [NP-1:0] m_role, m_obs, m_pin;
    logic          m_auto, m_step, m_valid, m_cum;

    always #5 clk = ~clk;

    pin_result_accum #(.NPINS(NP)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .step_strobe(step_strobe),
        .step_expect(step_expect), .cmp_above_hi(cmp_above_hi),
        .cmp_below_lo(cmp_below_lo), .sentence_end(sentence_end),
        .cum_clear(cum_clear), .pin_fail(pin_fail), .step_fail(step_fail),
        .step_valid(step_valid), .cum_fail(cum_fail)
    );

    function automatic logic [NP-1:0] judge(input logic [NP-1:0] role,
        input logic [NP-1:0] obs, input logic [NP-1:0] ex,
        input logic [NP-1:0] hi, input logic [NP-1:0] lo);
        logic [NP-1:0] r;
        for (int i = 0; i < NP; i++)
            r[i] = role[i] && obs[i] && (ex[i] ? !hi[i] : !lo[i]);
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [NP-1:0] act, input logic [NP-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        cfg_we = 0; cfg_addr = 0; cfg_wdata = 0; step_strobe = 0;
        step_expect = 0; cmp_above_hi = 0; cmp_below_lo = 0;
        sentence_end = 0; cum_clear = 0;
    endtask

    // One clock: predict from current inputs, clock, compare, commit.
    task automatic cycle();
        logic [NP-1:0] n_pin, now;
        logic n_step, n_cum, verdict;
        string creq;
        now    = judge(m_role, m_obs, step_expect, cmp_above_hi, cmp_below_lo);
        n_pin  = step_strobe ? now : m_pin;
        n_step = step_strobe ? (|now) : m_step;
        verdict = step_strobe ? (|now) : m_step;
        if (cum_clear) begin
            n_cum = 1'b0; creq = "R8";
        end else if (sentence_end && m_auto) begin
            n_cum = m_cum | verdict; creq = "R6";
        end else if (sentence_end) begin
            n_cum = m_cum; creq = "R7";
        end else begin
            n_cum = m_cum; creq = "R8";
        end
        @(posedge clk);
        #2;
        if (cfg_we) begin
            if (cfg_addr == 2'd0) m_role = cfg_wdata;
            else if (cfg_addr == 2'd1) m_obs = cfg_wdata;
            else if (cfg_addr == 2'd2) m_auto = cfg_wdata[0];
        end
        m_pin = n_pin; m_step = n_step; m_valid = step_strobe; m_cum = n_cum;
        check("R3", "pin_fail", pin_fail, m_pin);
        check("R5", "step_fail", NP'(step_fail), NP'(m_step));
        check("R5", "step_valid", NP'(step_valid), NP'(m_valid));
        check(creq, "cum_fail", NP'(cum_fail), NP'(m_cum));
        idle_inputs();
    endtask

    task automatic write_cfg(input logic [1:0] a, input logic [NP-1:0] d);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        cycle();
    endtask

    task automatic step(input logic [NP-1:0] ex, input logic [NP-1:0] hi,
                        input logic [NP-1:0] lo, input logic se);
        step_strobe = 1; step_expect = ex; cmp_above_hi = hi;
        cmp_below_lo = lo; sentence_end = se;
        cycle();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        rst_n = 0;
        m_role = '0; m_obs = '0; m_pin = '0;
        m_auto = 0; m_step = 0; m_valid = 0; m_cum = 0;
        repeat (3) @(posedge clk);
        #2;
        rst_n = 1;
        // R1: reset state
        check("R1", "pin_fail", pin_fail, '0);
        check("R1", "flags", {5'b0, step_fail, step_valid, cum_fail}, '0);
        // R1/R4: after reset no channel is monitored, so all-fail stimulus passes
        step('1, '0, '0, 1'b0);
        check("R1", "reset masks", pin_fail, '0);

        // R4: relevant but input-role channels are masked
        write_cfg(2'd1, '1);
        step('1, '0, '0, 1'b0);
        check("R4", "input role masked", pin_fail, '0);
        // R2: role write and strobe in the same cycle use the old roles
        cfg_we = 1; cfg_addr = 2'd0; cfg_wdata = 8'h0F;
        step_strobe = 1; step_expect = '1;
        cycle();
        check("R2", "same-cycle write", pin_fail, '0);
        step('1, '0, '0, 1'b0);
        check("R3", "high expected low seen", pin_fail, 8'h0F);
        // R4: unobserved outputs masked
        write_cfg(2'd1, 8'h05);
        step('0, '0, '0, 1'b0);
        check("R4", "unobserved masked", pin_fail, 8'h05);
        // R2: write to unused select ignored
        write_cfg(2'd3, '0);
        step('0, '0, '1, 1'b0);
        check("R2", "unused select", pin_fail, '0);

        // R7: accumulation off, sentence end ignored
        step('0, '0, '0, 1'b1);
        check("R7", "cum unchanged", NP'(cum_fail), '0);
        // R6: same-cycle strobe + sentence end uses fresh verdict
        write_cfg(2'd2, 8'h01);
        step('0, '0, '1, 1'b0);
        step('0, '0, '0, 1'b1);
        check("R6", "fresh verdict", NP'(cum_fail), 8'h01);
        // R8: sticky across passing sentence
        step('0, '0, '1, 1'b1);
        check("R8", "sticky", NP'(cum_fail), 8'h01);
        // R8: clear with accumulating sentence end, clear wins
        step('0, '0, '0, 1'b0);
        cum_clear = 1; sentence_end = 1;
        cycle();
        check("R8", "clear wins", NP'(cum_fail), '0);

        // Random phase
        write_cfg(2'd0, 8'hFF);
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 19) == 0) begin
                cfg_we = 1; cfg_addr = 2'($urandom_range(0, 3));
                cfg_wdata = NP'($urandom);
            end
            step_strobe  = ($urandom_range(0, 2) != 0);
            step_expect  = NP'($urandom);
            cmp_above_hi = NP'($urandom) | NP'($urandom);
            cmp_below_lo = NP'($urandom) | NP'($urandom);
            sentence_end = ($urandom_range(0, 5) == 0);
            cum_clear    = ($urandom_range(0, 40) == 0);
            cycle();
        end
        finish_run();
    end
endmodule